// File: doc/BRIEF.md
# Vector Scaled Address Generator

This block turns a base vector and an offset vector into a vector of memory addresses, one lane at a time. With each operand pair it takes a 32-bit instruction word. It decodes the lane width, how the offset is extended and a power-of-two scale from that word. Each offset is extended and then shifted left by the scale. The shifted offset is added to the base lane in the same position, and the sum wraps at the lane width.

Three offset modes exist:
- **Packed:** 32-bit or 64-bit lanes, with the offset taken unsigned at the full lane width.
- **Sign-extended:** 64-bit lanes whose offset comes from the low 32 bits of each offset lane, sign-extended.
- **Zero-extended:** 64-bit lanes whose offset comes from the low 32 bits of each offset lane, zero-extended.

The result is registered and appears one clock after the input strobe, together with the three register indices that the word carries. If a word fails the fixed-bit decode, the block produces no address vector. It raises an undefined-encoding flag for one cycle instead.

Top module: `vec_addr_gen`

## Requirements
- R1: A word is recognised only when bits 31:24 equal 8'h04, bit 21 is 1 and bits 15:12 equal 4'hA. Any other word is undefined.
- R2: When bit 23 is 1 and bit 22 is 0, the vector is split into VLEN/32 lanes of 32 bits. Each full 32-bit offset lane is treated as unsigned.
- R3: When bit 23 is 1 and bit 22 is 1, the vector is split into VLEN/64 lanes of 64 bits. Each full 64-bit offset lane is treated as unsigned.
- R4: When bit 23 is 0 and bit 22 is 0, the lanes are 64 bits wide. Each offset is bits 31:0 of its lane, sign-extended to 64 bits, and bits 63:32 of the offset lane are ignored.
- R5: When bit 23 is 0 and bit 22 is 1, the lanes are 64 bits wide. Each offset is bits 31:0 of its lane, zero-extended, and bits 63:32 of the offset lane are ignored.
- R6: The extended offset is shifted left by the value of bits 11:10 (0 to 3) before the add.
- R7: Each result lane is the base lane plus the scaled offset, truncated to the lane width, so overflow wraps. Lane 0 sits in the least significant bits of the operands and of the result.
- R8: out_valid follows in_valid with exactly one clock of latency. A synchronous reset clears out_valid, out_undef, out_vec and the index outputs.
- R9: An undefined word presented with in_valid gives out_valid=1 and out_undef=1 for that one cycle. In that cycle out_vec and all index outputs are zero.
- R10: For a recognised word, out_dst carries bits 4:0, out_nreg bits 9:5 and out_mreg bits 20:16, and out_undef is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and word are present |
| in_insn | input | 32 | Instruction word |
| in_base | input | VLEN | Base address vector, lane 0 in the LSBs |
| in_offs | input | VLEN | Offset vector, lane 0 in the LSBs |
| out_valid | output | 1 | Result present (one cycle after in_valid) |
| out_undef | output | 1 | Word did not decode |
| out_vec | output | VLEN | Address vector |
| out_dst | output | 5 | Destination register index |
| out_nreg | output | 5 | Base register index |
| out_mreg | output | 5 | Offset register index |

## Verification
The bench sends offsets with bit 31 set through both 32-bit modes. A design that swapped or ignored the extension would leave the upper word of the result at zero where all ones are expected, or the reverse. It also lets the upper offset half leak into the sum. Bases of all ones combined with nonzero offsets catch carries that escape into the next lane or sums that fail to wrap. Every scale is run in every mode. Random and single-bit-corrupted words show whether the decode checks each fixed bit, and a decoder that misses one would produce addresses where the undefined flag is expected.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic [VLEN-1:0] in_base,
  input  logic [VLEN-1:0] in_offs,
  output logic            out_valid,
  output logic            out_undef,
  output logic [VLEN-1:0] out_vec,
  output logic [4:0]      out_dst,
  output logic [4:0]      out_nreg,
  output logic [4:0]      out_mreg
);
  localparam int N32 = VLEN / 32;
  localparam int N64 = VLEN / 64;

  logic       hit, packed_m, sz_bit, narrow;
  logic [1:0] sh;
  logic [VLEN-1:0] sum32, sum64, nxt;

  assign hit      = (in_insn[31:24] == 8'h04) && in_insn[21] && (in_insn[15:12] == 4'hA);
  assign packed_m = in_insn[23];
  assign sz_bit   = in_insn[22];
  assign sh       = in_insn[11:10];
  assign narrow   = packed_m && !sz_bit;

  for (genvar g = 0; g < N32; g++) begin : g_w32
    assign sum32[g*32 +: 32] = in_base[g*32 +: 32] + (in_offs[g*32 +: 32] << sh);
  end

  for (genvar g = 0; g < N64; g++) begin : g_w64
    logic [63:0] raw, ext;
    assign raw = in_offs[g*64 +: 64];
    assign ext = packed_m ? raw : {{32{~sz_bit & raw[31]}}, raw[31:0]};
    assign sum64[g*64 +: 64] = in_base[g*64 +: 64] + (ext << sh);
  end

  assign nxt = narrow ? sum32 : sum64;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_vec   <= '0;
      out_dst   <= '0;
      out_nreg  <= '0;
      out_mreg  <= '0;
    end else begin
      out_valid <= in_valid;
      out_undef <= in_valid && !hit;
      if (in_valid) begin
        out_vec  <= hit ? nxt : '0;
        out_dst  <= hit ? in_insn[4:0]   : 5'd0;
        out_nreg <= hit ? in_insn[9:5]   : 5'd0;
        out_mreg <= hit ? in_insn[20:16] : 5'd0;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !out_valid && !out_undef); // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid && !out_undef); // R8
  AST_UNDEF_PAIRED: assert property (@(posedge clk) disable iff (rst) out_undef |-> out_valid); // R9
  AST_UNDEF_EMPTY: assert property (@(posedge clk) disable iff (rst) out_undef |-> (out_vec == '0 && out_dst == 5'd0)); // R9
  AST_DECODE_FLAG: assert property (@(posedge clk) disable iff (rst) in_valid && !hit |=> out_undef); // R1
endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;
  localparam int VLEN = 256;
  logic clk = 1'b0;
  logic rst, in_valid;
  logic [31:0] in_insn;
  logic [VLEN-1:0] in_base, in_offs;
  logic out_valid, out_undef;
  logic [VLEN-1:0] out_vec;
  logic [4:0] out_dst, out_nreg, out_mreg;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  vec_addr_gen #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_base(in_base), .in_offs(in_offs), .out_valid(out_valid),
    .out_undef(out_undef), .out_vec(out_vec), .out_dst(out_dst),
    .out_nreg(out_nreg), .out_mreg(out_mreg));

  function automatic logic [31:0] mk(bit p, bit s, logic [1:0] k, logic [4:0] d);
    return {8'h04, p, s, 1'b1, 5'd19, 4'hA, k, 5'd11, d};
  endfunction

  function automatic bit recog(logic [31:0] w);
    return w[31:24] == 8'h04 && w[21] == 1'b1 && w[15:12] == 4'hA;
  endfunction

  function automatic logic [VLEN-1:0] model(logic [31:0] w, logic [VLEN-1:0] b, logic [VLEN-1:0] o);
    logic [VLEN-1:0] r;
    longint unsigned acc, ov;
    int k;
    k = int'(w[11:10]);
    r = '0;
    if (w[23] && !w[22]) begin
      for (int i = 0; i < VLEN / 32; i++) begin
        ov  = longint'(o[i*32 +: 32]) << k;
        acc = longint'(b[i*32 +: 32]) + ov;
        r[i*32 +: 32] = acc[31:0];
      end
    end else begin
      for (int i = 0; i < VLEN / 64; i++) begin
        ov = o[i*64 +: 64];
        if (!w[23]) begin
          if (w[22]) ov = {32'd0, ov[31:0]};
          else       ov = longint'($signed(ov[31:0]));
        end
        acc = b[i*64 +: 64] + (ov << k);
        r[i*64 +: 64] = acc;
      end
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] w, logic [VLEN-1:0] b, logic [VLEN-1:0] o, string tag);
    logic [VLEN-1:0] ev;
    bit eu, m;
    @(negedge clk);
    in_valid = v; in_insn = w; in_base = b; in_offs = o;
    m  = recog(w);
    eu = v && !m;
    ev = m ? model(w, b, o) : '0;
    @(posedge clk); #1;
    chk(out_valid == v && out_undef == eu, {tag, " R8 valid/undef"},
        {out_valid, out_undef}, {v, eu});
    if (v) begin
      chk(out_vec == ev, {tag, " vec"}, out_vec, ev);
      chk(out_dst == (m ? w[4:0] : 5'd0) && out_nreg == (m ? w[9:5] : 5'd0) &&
          out_mreg == (m ? w[20:16] : 5'd0), {tag, " R10 indices"},
          {out_dst, out_nreg, out_mreg}, {(m ? w[4:0] : 5'd0), (m ? w[9:5] : 5'd0), (m ? w[20:16] : 5'd0)});
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] ones, hi31, mix;
    logic [31:0] w;
    rst = 1'b1; in_valid = 1'b0; in_insn = '0; in_base = '0; in_offs = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !out_undef && out_vec == '0 && out_dst == 0, "R8 reset state",
        {out_valid, out_undef}, '0);
    @(negedge clk); rst = 1'b0;

    ones = '1;
    hi31 = '0;
    for (int i = 0; i < VLEN / 32; i++) hi31[i*32 +: 32] = 32'h8000_0000 | i;
    mix = '0;
    for (int i = 0; i < VLEN / 64; i++) mix[i*64 +: 64] = 64'hDEAD_BEEF_8000_0003 + i;

    // R2 R3 R4 R5 R6 R7: every mode with every scale, several patterns
    for (int k = 0; k < 4; k++) begin
      step(1, mk(1, 0, k[1:0], 5'd1), ones, hi31, "R2 packed32");
      step(1, mk(1, 1, k[1:0], 5'd2), ones, mix,  "R3 packed64");
      step(1, mk(0, 0, k[1:0], 5'd3), ones, hi31, "R4 sext");
      step(1, mk(0, 1, k[1:0], 5'd4), ones, mix,  "R5 zext");
      step(1, mk(0, 0, k[1:0], 5'd5), '0,   mix,  "R6 sext scale");
      step(1, mk(0, 1, k[1:0], 5'd6), rnd(), hi31, "R7 zext wrap");
    end

    // R4: sign-extend lane 0, 0x80000000 << 1 from base 0
    step(1, mk(0, 0, 2'd1, 5'd7), '0, {{(VLEN-64){1'b0}}, 64'h1234_5678_8000_0000}, "R4 lane0");
    chk(out_vec[63:0] == 64'hFFFF_FFFF_0000_0000, "R4 lane0 sign", out_vec, 64'hFFFF_FFFF_0000_0000);
    // R5: zero-extend ignores upper half, scale 8
    step(1, mk(0, 1, 2'd3, 5'd8), '0, {{(VLEN-64){1'b0}}, 64'hDEAD_0000_8000_0000}, "R5 lane0");
    chk(out_vec[63:0] == 64'h0000_0004_0000_0000, "R5 lane0 zero", out_vec, 64'h0000_0004_0000_0000);
    // R7: packed32 lane 0 wraps without touching lane 1
    step(1, mk(1, 0, 2'd0, 5'd9), {{(VLEN-32){1'b0}}, 32'hFFFF_FFFF}, {{(VLEN-32){1'b0}}, 32'd2}, "R7 lane0");
    chk(out_vec[63:0] == 64'h0000_0000_0000_0001, "R7 no carry", out_vec, 64'h1);

    // R8: idle cycles and back-to-back
    step(0, mk(1, 1, 0, 0), rnd(), rnd(), "R8 idle");
    step(0, '0, rnd(), rnd(), "R8 idle2");
    step(1, mk(1, 1, 2'd2, 5'd31), rnd(), rnd(), "R8 b2b a");
    step(1, mk(0, 1, 2'd1, 5'd30), rnd(), rnd(), "R8 b2b b");

    // R1 R9: each fixed bit corrupted
    for (int b = 0; b < 32; b++) begin
      w = mk(1, 1, 2'd1, 5'd12) ^ (32'd1 << b);
      step(1, w, rnd(), rnd(), "R1 R9 bitflip");
    end
    // R1: random words, R10 random valid words
    for (int i = 0; i < 60; i++) step(1, $urandom, rnd(), rnd(), "R1 random");
    for (int i = 0; i < 60; i++) begin
      w = $urandom;
      w[31:24] = 8'h04; w[21] = 1'b1; w[15:12] = 4'hA;
      step(i % 5 != 0, w, rnd(), rnd(), "R10 random ok");
    end

    // R8: reset mid-stream clears outputs
    step(1, mk(1, 1, 0, 5'd3), ones, ones, "R8 pre-reset");
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    chk(!out_valid && !out_undef && out_vec == '0, "R8 sync reset", {out_valid, out_undef}, '0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule